// File: doc/BRIEF.md
# Break-Field Reception Controller

This block is the control and status register of a UART receiver that can wait for a break field, the long low period that opens a LIN-style frame. Over an 8-bit bus port, software sets the bit order and the polarity of the transmit line. It also arms the break hunt by writing a self-clearing trigger bit, then reads a status flag that shows whether the hunt is still running.

A small detector sits beside the register. On every bit-period strobe it samples the receive line and counts consecutive low samples. When the line goes high again after a long enough low time, the hunt ends. The status flag drops and a one-cycle interrupt pulse is raised. When the line goes high too early, the detector starts counting again and the flag stays up. The shifter and the baud generator are outside this block. The baud generator only supplies the `bit_tick` strobe.

Top module: `brk_rx_ctrl`

## Requirements
- R1: After reset, `bus_rdata` reads 0x16 and `txd_out` follows `txd_raw` unchanged.
- R2: Read layout: bit 7 is the hunt flag, bit 6 always reads 0, bits 5..2 always read 0101, bit 1 is the order select and bit 0 is the polarity select. Writes never change bits 7..2 directly.
- R3: A bus write with bit 6 = 1 while `pwr_en` and `rx_en` are both 1 sets the hunt flag (bit 7) in the following cycle.
- R4: A bus write with bit 6 = 1 while `pwr_en` or `rx_en` is 0 has no effect on the hunt flag.
- R5: While `pwr_en` or `rx_en` is 0, the hunt flag reads 0 from the next cycle on.
- R6: During a hunt, at least BRK_BITS (default 11) consecutive strobes sampling `rxd` low, followed by a strobe sampling it high, clear the hunt flag.
- R7: During a hunt, a strobe sampling `rxd` high after fewer than BRK_BITS low strobes (but at least one) keeps the flag at 1 and restarts the low count, so a later full-length break still completes.
- R8: Bit 1 drives `lsb_first` (0 = MSB first, 1 = LSB first).
- R9: Bit 0 selects the transmit polarity: `txd_out` equals `txd_raw` when it is 0 and the inverse of `txd_raw` when it is 1.
- R10: Writes update bits 1 and 0 only while `tx_en` and `rx_en` are both 0. Otherwise those bits keep their value.
- R11: A trigger write accepted during a hunt discards the low count gathered so far.
- R12: A successful break produces exactly one `brk_irq` pulse, one cycle wide, in the same cycle the flag falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read value |
| pwr_en | input | 1 | UART power enable |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| rxd | input | 1 | Receive serial line |
| txd_raw | input | 1 | Transmit bit from the shifter |
| txd_out | output | 1 | Transmit line after polarity select |
| lsb_first | output | 1 | Bit order to the datapath |
| brk_irq | output | 1 | Break-received interrupt pulse |

## Verification
A hunt state that is wrongly lost or wrongly kept shows up on bit 7 of `bus_rdata` within one cycle of the write or enable change that caused it. A detector count that is not cleared, or that saturates at the wrong value, shows only when the line next returns high. At that point the flag falls too early or too late, and `brk_irq` is missing or extra, two cycles after the strobe. A corrupted configuration bit is visible at once on `lsb_first`, on `txd_out` and on the readback.

// File: rtl/brk_pkg.sv
// Shared definitions for the break-field reception controller.
// Assumes: register layout is fixed; the hunt state needs one bit.
package brk_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_HUNT = 1'b1} brk_state_e;

    localparam int FLAG_POS  = 7;
    localparam int TRIG_POS  = 6;
    localparam int ORDER_POS = 1;
    localparam int INV_POS   = 0;
    localparam logic [3:0] FIXED_BITS = 4'b0101;
    localparam logic [1:0] CFG_RESET  = 2'b10;
endpackage

// File: rtl/brk_cfg_reg.sv
// Holds bit-order and transmit-polarity selects, and applies polarity to TxD.
// Assumes: bits may only change while transmit and receive are both disabled.
module brk_cfg_reg
    import brk_pkg::*;
#(
    parameter int CFG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_cfg,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic             txd_raw,
    output logic [CFG_W-1:0] cfg_q,
    output logic             txd_out
);
    logic unlocked;

    // Configuration may change only when both directions are off.
    always_comb unlocked = !tx_en && !rx_en;

    // Configuration storage with reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en && unlocked) begin
            cfg_q <= wr_cfg;
        end
    end

    // Polarity select on the transmit line.
    always_comb txd_out = cfg_q[INV_POS] ? ~txd_raw : txd_raw;
endmodule

// File: rtl/brk_detector.sv
// Counts consecutive low RxD samples on bit strobes; a high sample ends the run.
// Assumes: bit_tick is one cycle wide; count is cleared when disarmed or restarted.
module brk_detector #(
    parameter int BRK_BITS = 11,
    localparam int CNT_W = $clog2(BRK_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic restart,
    input  logic bit_tick,
    input  logic rxd,
    output logic succ_q,
    output logic err_q
);
    localparam logic [CNT_W-1:0] THR = CNT_W'(BRK_BITS);

    logic [CNT_W-1:0] low_cnt;
    logic             sample_hi;
    logic             sample_lo;

    // Strobe qualifiers while armed.
    always_comb begin
        sample_hi = armed && !restart && bit_tick && rxd;
        sample_lo = armed && !restart && bit_tick && !rxd;
    end

    // Saturating low-run counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || restart || sample_hi) begin
            low_cnt <= '0;
        end else if (sample_lo && low_cnt != THR) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Registered outcome pulses at the end of a low run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            succ_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            succ_q <= sample_hi && (low_cnt >= THR);
            err_q  <= sample_hi && (low_cnt != '0) && (low_cnt < THR);
        end
    end
endmodule

// File: rtl/brk_seq.sv
// Hunt sequencer: accepts the trigger, holds the status flag, raises the interrupt.
// Assumes: a trigger wins over a detector outcome arriving in the same cycle.
module brk_seq
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic rx_en,
    input  logic trig_req,
    input  logic succ,
    input  logic err,
    output logic hunting,
    output logic restart,
    output logic irq
);
    brk_state_e state_q, state_d;
    logic       live;
    logic       irq_d;

    // The receive path is live only with power and receive enabled.
    always_comb live = pwr_en && rx_en;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        irq_d   = 1'b0;
        restart = 1'b0;
        if (!live) begin
            state_d = ST_IDLE;
        end else if (trig_req) begin
            state_d = ST_HUNT;
            restart = 1'b1;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    if (succ) begin
                        state_d = ST_IDLE;
                        irq_d   = 1'b1;
                    end else if (err) begin
                        state_d = ST_HUNT;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            irq     <= 1'b0;
        end else begin
            state_q <= state_d;
            irq     <= irq_d;
        end
    end

    // Flag view of the state.
    always_comb hunting = (state_q == ST_HUNT);
endmodule

// File: rtl/brk_rx_ctrl.sv
// Top of the break-field reception controller: bus register, sequencer, detector.
// Assumes: single-cycle bus writes, reads are combinational from registers.
module brk_rx_ctrl
    import brk_pkg::*;
#(
    parameter int BRK_BITS = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       pwr_en,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       bit_tick,
    input  logic       rxd,
    input  logic       txd_raw,
    output logic       txd_out,
    output logic       lsb_first,
    output logic       brk_irq
);
    localparam int CFG_W = 2;

    logic [CFG_W-1:0] cfg_q;
    logic             trig_req;
    logic             hunting;
    logic             restart;
    logic             succ;
    logic             err;

    // Trigger request from a bus write of bit 6.
    always_comb trig_req = bus_wr && bus_wdata[TRIG_POS];

    brk_cfg_reg #(.CFG_W(CFG_W)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_cfg  (bus_wdata[CFG_W-1:0]),
        .tx_en   (tx_en),
        .rx_en   (rx_en),
        .txd_raw (txd_raw),
        .cfg_q   (cfg_q),
        .txd_out (txd_out)
    );

    brk_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_en   (pwr_en),
        .rx_en    (rx_en),
        .trig_req (trig_req),
        .succ     (succ),
        .err      (err),
        .hunting  (hunting),
        .restart  (restart),
        .irq      (brk_irq)
    );

    brk_detector #(.BRK_BITS(BRK_BITS)) i_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .armed    (hunting),
        .restart  (restart),
        .bit_tick (bit_tick),
        .rxd      (rxd),
        .succ_q   (succ),
        .err_q    (err)
    );

    // Readback assembly; trigger bit always reads zero.
    always_comb begin
        bus_rdata = {hunting, 1'b0, FIXED_BITS, cfg_q};
        lsb_first = cfg_q[ORDER_POS];
    end
endmodule

// File: rtl/brk_rx_ctrl_chk.sv
// Property checker for brk_rx_ctrl, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module brk_rx_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       pwr_en,
    input logic       tx_en,
    input logic       rx_en,
    input logic       lsb_first,
    input logic       txd_out,
    input logic       txd_raw,
    input logic       brk_irq
);
    assert_trig_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[6] && pwr_en && rx_en) |=> bus_rdata[7]);

    assert_flag_off_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_en && rx_en) |=> !bus_rdata[7]);

    assert_trig_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rdata[7] && !(pwr_en && rx_en)) |=> !bus_rdata[7]);

    assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_en) |=> ($stable(lsb_first) && $stable(bus_rdata[0])));

    assert_irq_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |=> !brk_irq);

    assert_irq_with_flag_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq |-> (!bus_rdata[7] && $past(bus_rdata[7])));
endmodule

bind brk_rx_ctrl brk_rx_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwr_en    (pwr_en),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .lsb_first (lsb_first),
    .txd_out   (txd_out),
    .txd_raw   (txd_raw),
    .brk_irq   (brk_irq)
);

// File: tb/test_brk_rx_ctrl.sv
module test_brk_rx_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pwr_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic       bit_tick = 1'b0, rxd = 1'b1, txd_raw = 1'b0;
    logic       txd_out, lsb_first, brk_irq;

    int n_chk = 0, n_bad = 0, irq_cnt = 0;
    logic irq_prev = 1'b0;
    logic [1:0] m_cfg = 2'b10;
    logic       m_flag = 1'b0;

    always #2.5 clk = ~clk;

    brk_rx_ctrl i_brk_rx_ctrl (.*);

    // Count interrupt pulses and check their width (R12).
    always @(negedge clk) begin
        if (rst_n && brk_irq) irq_cnt++;
        if (rst_n && brk_irq && irq_prev) begin
            n_bad++;
            $display("FAIL R12 irq wider than one cycle: act=1 exp=0");
        end
        irq_prev <= brk_irq;
    end

    function automatic logic [7:0] exp_rd(input logic f, input logic [1:0] c);
        return {f, 1'b0, 4'b0101, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bits(input logic lvl, input int n);
        for (int k = 0; k < n; k++) begin
            rxd = lvl;
            repeat (3) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset readback", bus_rdata, 8'h16);
        txd_raw = 1'b1;
        #1 chk("R1 txd normal after reset", txd_out, 1'b1);
        chk("R8 lsb_first reset", lsb_first, 1'b1);

        // Random register traffic with rxd idle high.
        for (int i = 0; i < 200; i++) begin
            logic [7:0] d;
            logic lk;
            d = 8'($urandom);
            pwr_en = 1'($urandom); tx_en = 1'($urandom_range(0, 3) == 0);
            rx_en = 1'($urandom);
            lk = tx_en || rx_en;
            if (!lk) m_cfg = d[1:0];
            if (!(pwr_en && rx_en)) m_flag = 1'b0;
            else if (d[6]) m_flag = 1'b1;
            wr(d);
            chk(lk ? "R10 cfg locked" : "R2 R3 R4 R5 readback", bus_rdata, exp_rd(m_flag, m_cfg));
            txd_raw = 1'($urandom);
            #1;
            chk("R9 txd polarity", txd_out, txd_raw ^ m_cfg[0]);
            chk("R8 order out", lsb_first, m_cfg[1]);
        end

        // Directed: trigger ignored when disabled (R4).
        pwr_en = 1'b1; rx_en = 1'b0; tx_en = 1'b0;
        @(negedge clk);
        wr(8'h40);
        chk("R4 trigger ignored", bus_rdata[7], 1'b0);
        rx_en = 1'b1;
        @(negedge clk);
        chk("R4 still idle after enable", bus_rdata[7], 1'b0);

        // Success at exactly BRK_BITS low samples (R6, R12).
        wr(8'h40);
        chk("R3 flag set", bus_rdata[7], 1'b1);
        chk("R2 trigger reads 0", bus_rdata[6], 1'b0);
        base = irq_cnt;
        bits(1'b0, 11); bits(1'b1, 1);
        repeat (3) @(negedge clk);
        chk("R6 flag cleared", bus_rdata[7], 1'b0);
        chk("R12 one irq", irq_cnt - base, 1);

        // Too short (10): error keeps flag, then full break succeeds (R7).
        wr(8'h40);
        base = irq_cnt;
        bits(1'b0, 10); bits(1'b1, 1);
        repeat (3) @(negedge clk);
        chk("R7 flag held on error", bus_rdata[7], 1'b1);
        chk("R7 no irq on error", irq_cnt - base, 0);
        bits(1'b0, 15); bits(1'b1, 1);
        repeat (3) @(negedge clk);
        chk("R7 recover success", bus_rdata[7], 1'b0);
        chk("R7 irq after recovery", irq_cnt - base, 1);

        // Rewrite during hunt discards count (R11).
        wr(8'h40);
        base = irq_cnt;
        bits(1'b0, 8);
        wr(8'h40);
        bits(1'b0, 4); bits(1'b1, 1);
        repeat (3) @(negedge clk);
        chk("R11 restart gives error", bus_rdata[7], 1'b1);
        chk("R11 no irq", irq_cnt - base, 0);

        // Disabling receive drops the flag (R5).
        rx_en = 1'b0;
        @(negedge clk);
        chk("R5 flag off", bus_rdata[7], 1'b0);
        rx_en = 1'b1;

        // Random break lengths.
        for (int i = 0; i < 30; i++) begin
            int len;
            len = $urandom_range(1, 16);
            wr(8'h40);
            base = irq_cnt;
            bits(1'b0, len); bits(1'b1, 1);
            repeat (3) @(negedge clk);
            chk(len >= 11 ? "R6 random success" : "R7 random error", bus_rdata[7], len < 11);
            chk("R12 random irq count", irq_cnt - base, len >= 11);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule